// File: doc/BRIEF.md
# Soft-Decision Add-Compare-Select Step

This block carries out one trellis step for a four-state Viterbi decoder of the rate-1/2, constraint-length-3 convolutional code whose two generator taps are 111 and 101. Each step takes one received pair of 3-bit soft values, each from 0 to 7, so the pair is one point of an 8-by-8 grid. For every state it adds a branch metric to each of the two predecessor metrics, keeps the smaller sum, and records which predecessor won.

The branch metric is the squared Euclidean distance from the received pair to a branch word. A code bit of 0 is placed at level 0 and a code bit of 1 at level 7. No square root is taken, so the metric is an integer from 0 to 98. A smaller metric marks a more likely path. After the compare and select, the new metrics are shifted down so that the best state sits at zero. The outputs are registered. A traceback unit downstream consumes the four decision bits of each step, and the metrics are fed back for the next step.

Top module: `soft_acs`

## Requirements
- R1: While rst_n is low, and after it is released until the first accepted pair, the metric of state 0 is 0 and the metric of every other state is INIT. out_valid and all decision bits are 0.
- R2: The branch metric for received pair (a,b) and code bits (c1,c2) is (a-7*c1)^2 + (b-7*c2)^2. For example, from the reset state the pair (5,4) yields metrics 28, 263, 0, 263 for states 0 to 3, with decision bits 4'b1000.
- R3: State index n = 2*s1 + s0, where s1 is the newest message bit and s0 the one before it. State n = {u, s1} is entered from predecessors 2*s1 + x, for x in {0,1}, with branch word c1 = u^s1^x and c2 = u^x.
- R4: Each new state metric is the smaller of its two predecessor-plus-branch sums. Decision bit n (dec_out[n]) is x, the low bit of the chosen predecessor index.
- R5: When both sums are equal, the predecessor with the lower index (x = 0) is chosen and the decision bit is 0.
- R6: After every accepted pair, the new metrics are the selected sums minus the smallest of the four, so at least one reported metric is 0 and none reaches 2^(MW-1).
- R7: An accepted pair (in_valid high at a rising edge) produces new metrics, decisions and out_valid high on that edge. out_valid is low after any edge where in_valid was low.
- R8: While in_valid is low, the metrics and decision bits hold their values whatever the soft inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A soft pair is present this cycle |
| soft_a | input | 3 | Soft value of the first code bit (0..7) |
| soft_b | input | 3 | Soft value of the second code bit (0..7) |
| out_valid | output | 1 | New metrics and decisions produced by the last edge |
| metric_out | output | 4*MW | State metrics, state n at bits [n*MW +: MW] |
| dec_out | output | 4 | Decision bit per state, bit n for state n |

## Verification
A wrong branch word or a miswired predecessor shows on the very next edge. It appears as a metric that differs from a step computed from the trellis rules, and usually also as a flipped decision bit. A normalisation fault shows as a step with no zero metric, and then as metrics that drift upward over a few steps. Tie handling is visible only when two sums are equal, so the reset state is used: there, the inputs (0,0) force equal sums into states 1 and 3, and a wrong tie rule sets those decision bits in the first output.

// File: rtl/soft_acs.sv
module soft_acs #(
  parameter int MW   = 10,
  parameter int INIT = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    soft_a,
  input  logic [2:0]    soft_b,
  output logic          out_valid,
  output logic [4*MW-1:0] metric_out,
  output logic [3:0]    dec_out
);
  localparam int NS = 4;
  localparam int BW = 7;
  localparam int SW = MW + 1;
  localparam logic [2:0] HI = 3'd7;

  function automatic logic [BW-1:0] sq3(input logic [2:0] v);
    logic [5:0] e;
    e = {3'b000, v};
    return BW'(e * e);
  endfunction

  logic [MW-1:0] pm  [NS];
  logic [BW-1:0] bm  [NS];
  logic [SW-1:0] win [NS];
  logic [NS-1:0] pick;
  logic [SW-1:0] low;

  for (genvar w = 0; w < NS; w++) begin : g_bm
    localparam int C1 = (w >> 1) & 1;
    localparam int C2 = w & 1;
    assign bm[w] = sq3(C1 != 0 ? HI - soft_a : soft_a) + sq3(C2 != 0 ? HI - soft_b : soft_b);
  end

  for (genvar n = 0; n < NS; n++) begin : g_acs
    localparam int B1 = (n >> 1) & 1;
    localparam int B0 = n & 1;
    localparam int W0 = 2 * (B1 ^ B0) + B1;
    localparam int W1 = 3 - W0;
    localparam int P0 = 2 * B0;
    localparam int P1 = 2 * B0 + 1;
    logic [SW-1:0] sum0, sum1;
    assign sum0    = SW'(pm[P0]) + SW'(bm[W0]);
    assign sum1    = SW'(pm[P1]) + SW'(bm[W1]);
    assign pick[n] = sum1 < sum0;
    assign win[n]  = pick[n] ? sum1 : sum0;
    assign metric_out[n*MW +: MW] = pm[n];
  end

  always_comb begin
    low = win[0];
    for (int i = 1; i < NS; i++)
      if (win[i] < low) low = win[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) pm[i] <= (i == 0) ? '0 : MW'(INIT);
      dec_out   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        for (int i = 0; i < NS; i++) pm[i] <= MW'(win[i] - low);
        dec_out <= pick;
      end
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R7
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R7
  AST_HOLD_METRICS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(metric_out) && $stable(dec_out)));  // R8
  AST_MIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pm[0] == '0 || pm[1] == '0 || pm[2] == '0 || pm[3] == '0));  // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pm[0][MW-1] == 1'b0 && pm[1][MW-1] == 1'b0 &&
                   pm[2][MW-1] == 1'b0 && pm[3][MW-1] == 1'b0));  // R6
endmodule

// File: tb/tb_soft_acs.sv
module tb_soft_acs;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 10;
  localparam int INIT = 256;
  localparam int NV = 16;
  localparam logic [5:0] VEC [NV] = '{
    {3'd7,3'd7}, {3'd6,3'd1}, {3'd0,3'd7}, {3'd3,3'd4},
    {3'd7,3'd0}, {3'd1,3'd1}, {3'd5,3'd6}, {3'd2,3'd7},
    {3'd0,3'd0}, {3'd4,3'd3}, {3'd7,3'd2}, {3'd6,3'd6},
    {3'd1,3'd5}, {3'd3,3'd3}, {3'd0,3'd6}, {3'd7,3'd5}};

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [2:0] soft_a = 0, soft_b = 0;
  logic out_valid;
  logic [4*MW-1:0] metric_out;
  logic [3:0] dec_out;
  int checks = 0, errors = 0;
  int em [4];
  logic [3:0] ed;
  bit done = 0;

  soft_acs #(.MW(MW), .INIT(INIT)) dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .soft_a(soft_a), .soft_b(soft_b), .out_valid(out_valid), .metric_out(metric_out), .dec_out(dec_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input bit vld);
    check(out_valid == vld, {tag, " R7 out_valid"}, out_valid, vld);
    for (int n = 0; n < 4; n++)
      check(int'(metric_out[n*MW +: MW]) == em[n], {tag, " metric"}, metric_out[n*MW +: MW], em[n]);
    check(dec_out == ed, {tag, " R4 decisions"}, dec_out, ed);
  endtask

  task automatic model_reset();
    em[0] = 0; em[1] = INIT; em[2] = INIT; em[3] = INIT; ed = 0;
  endtask

  task automatic model_step(input int a, input int b);
    int nm [4];
    int lo;
    for (int n = 0; n < 4; n++) begin
      int u, s1, best, bx;
      u = n >> 1; s1 = n & 1; best = 0; bx = 0;
      for (int x = 0; x < 2; x++) begin
        int c1, c2, c;
        c1 = u ^ s1 ^ x; c2 = u ^ x;
        c = em[2*s1 + x] + (a - 7*c1)*(a - 7*c1) + (b - 7*c2)*(b - 7*c2);
        if (x == 0 || c < best) begin best = c; bx = x; end
      end
      nm[n] = best; ed[n] = bx[0];
    end
    lo = nm[0];
    for (int n = 1; n < 4; n++) if (nm[n] < lo) lo = nm[n];
    for (int n = 0; n < 4; n++) em[n] = nm[n] - lo;
  endtask

  task automatic apply(input logic [2:0] a, input logic [2:0] b);
    soft_a = a; soft_b = b; in_valid = 1;
    model_step(a, b);
    @(negedge clk);
  endtask

  initial begin
    repeat (CLK_PERIOD * 100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check_all("R1 during reset", 0);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 after release", 0);

    apply(3'd5, 3'd4);
    in_valid = 0;
    check(int'(metric_out[0 +: MW]) == 28, "R2 state0 (5,4)", metric_out[0 +: MW], 28);
    check(int'(metric_out[MW +: MW]) == 263, "R2 state1 (5,4)", metric_out[MW +: MW], 263);
    check(int'(metric_out[2*MW +: MW]) == 0, "R2 state2 (5,4)", metric_out[2*MW +: MW], 0);
    check(int'(metric_out[3*MW +: MW]) == 263, "R2 state3 (5,4)", metric_out[3*MW +: MW], 263);
    check(dec_out == 4'b1000, "R2 decisions (5,4)", dec_out, 4'b1000);
    check_all("R3 model (5,4)", 1);

    for (int k = 0; k < 3; k++) begin
      soft_a = 3'(k * 3 + 1); soft_b = 3'(7 - k);
      @(negedge clk);
      check_all("R8 hold", 0);
    end

    for (int i = 0; i < NV; i++) begin
      int z;
      apply(VEC[i][5:3], VEC[i][2:0]);
      check_all("R3 table", 1);
      z = 0;
      for (int n = 0; n < 4; n++) if (metric_out[n*MW +: MW] == 0) z++;
      check(z > 0, "R6 zero metric present", z, 1);
    end
    in_valid = 0;
    @(negedge clk);
    check_all("R7 idle after burst", 0);

    rst_n = 0;
    model_reset();
    @(negedge clk);
    check_all("R1 second reset", 0);
    rst_n = 1;
    @(negedge clk);
    apply(3'd0, 3'd0);
    in_valid = 0;
    check(dec_out[1] == 1'b0, "R5 tie state1", dec_out[1], 0);
    check(dec_out[3] == 1'b0, "R5 tie state3", dec_out[3], 0);
    check(int'(metric_out[MW +: MW]) == 305, "R5 state1 metric", metric_out[MW +: MW], 305);
    check(int'(metric_out[2*MW +: MW]) == 98, "R4 state2 metric", metric_out[2*MW +: MW], 98);
    check_all("R5 model (0,0)", 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule